// File: doc/BRIEF.md
# Cascadable Parity Generator and Checker with Shared Parity Line

This block computes odd parity over a data word built from chained nine-input parity slices. One parity line serves two purposes, and a registered transmit-mode control picks between them. In generate mode the block drives the line with the parity bit it computes. In check mode it releases the line, samples the value that another agent drives onto it, and pulls an active-low error flag when that value disagrees with the data.

The bidirectional pin is split into three signals: an incoming line value, an outgoing line value and an output enable. The pad ring joins them. The parameter `N_SLICES` sets the word width. The first slice takes nine data bits. Every later slice takes the odd-count result of the slice before it plus eight new data bits. The word is therefore `8*N_SLICES+1` bits wide, which is 17 bits for the default of 2.

The parity tree and the error verdict are combinational. Only the mode and the output enable pass through registers, so that reset holds the line released and the error flag inactive.

Top module: `par_bus_unit`

## Requirements
- R1: `par_out` is 1 when the number of ones across all `data_in` bits is even, zero included. It is 0 when that number is odd. This holds in both modes.
- R2: `check_mode` is sampled at each rising clock edge while `rst` is low. Value 0 selects generate mode and value 1 selects check mode. `par_oe` then equals the inverse of the sampled value from that edge until the next edge.
- R3: While the registered mode is generate, `err_n` is 1 whatever `data_in` and `par_in` are.
- R4: While the registered mode is check, `err_n` is 0 exactly when the ones in `data_in` plus `par_in` add up to an even count. It is 1 when that count is odd.
- R5: While the registered mode is check, `par_oe` is 0, so the block does not drive the line.
- R6: `rst` is synchronous and active high. After a rising edge with `rst` high, `par_oe` is 0 and `err_n` is 1 for any `check_mode`, `data_in` and `par_in`.
- R7: With `N_SLICES` = 2, `data_in` is 17 bits wide. A single one at any bit position, including the last bit of the first slice and the top bit of the second slice, gives `par_out` = 0.
- R8: The check-mode verdict is combinational. A change of `par_in` changes `err_n` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the mode and enable registers |
| rst | input | 1 | Synchronous active-high reset |
| check_mode | input | 1 | Mode select: 0 generate, 1 check |
| data_in | input | 8*N_SLICES+1 | Data word covered by the parity |
| par_in | input | 1 | Value sampled from the shared parity line |
| par_out | output | 1 | Parity value offered to the shared line |
| par_oe | output | 1 | Drive enable for the shared parity line |
| err_n | output | 1 | Active-low parity mismatch flag |

## Verification
A fixed vector table covers several data patterns:
- all zeros and all ones;
- single ones at the first bit and at the slice boundaries, which shows whether the slices are linked through the chain;
- small clusters that flip the parity.

Each of these patterns is applied in generate mode and in check mode, and with the line at both levels. This separates a tree that is wrong from an error flag that has the wrong polarity.

A walking single one over all 17 positions shows that no bit is dropped at the junction between the slices. Random words with random modes cover wider patterns. Directed tests cover three further cases: reset overriding a drive request, the one-cycle delay of the enable after a mode change, and a flip of the line in the middle of a cycle, which must change the flag without a clock edge.

// File: rtl/parbus_pkg.sv
package parbus_pkg;

  localparam int unsigned SLICE_BITS = 9;
  localparam int unsigned FRESH_BITS = SLICE_BITS - 1;

  typedef enum logic {
    MODE_GEN   = 1'b0,
    MODE_CHECK = 1'b1
  } pmode_e;

  // width of the word covered by n chained slices
  function automatic int unsigned word_bits(int unsigned n);
    return FRESH_BITS * n + 1;
  endfunction

  // 1 when an odd number of the nine inputs are high
  function automatic logic odd_ones9(logic [SLICE_BITS-1:0] v);
    return ^v;
  endfunction

  // value placed on the line: high for an even count
  function automatic logic line_value(logic odd);
    return ~odd;
  endfunction

  // active-low verdict: low when data plus line have an even count of ones
  function automatic logic verdict_n(pmode_e m, logic odd, logic line);
    if (m == MODE_GEN) return 1'b1;
    return odd ^ line;
  endfunction

endpackage

// File: rtl/par_slice.sv
module par_slice
  import parbus_pkg::*;
(
  input  logic [SLICE_BITS-1:0] bits_i,
  output logic                  odd_o
);

  always_comb odd_o = odd_ones9(bits_i);

endmodule

// File: rtl/par_chain.sv
module par_chain
  import parbus_pkg::*;
#(
  parameter  int unsigned N_SLICES = 2,
  localparam int unsigned DW       = word_bits(N_SLICES)
) (
  input  logic [DW-1:0] data_i,
  output logic          total_odd_o
);

  logic [N_SLICES-1:0] link;

  for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
    logic [SLICE_BITS-1:0] feed;
    if (k == 0) begin : g_head
      always_comb feed = data_i[SLICE_BITS-1:0];
    end else begin : g_tail
      always_comb feed = {data_i[FRESH_BITS*k+FRESH_BITS : FRESH_BITS*k+1], link[k-1]};
    end
    par_slice u_slice (
      .bits_i (feed),
      .odd_o  (link[k])
    );
  end

  always_comb total_odd_o = link[N_SLICES-1];

endmodule

// File: rtl/par_mode_ctl.sv
module par_mode_ctl
  import parbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   check_mode_i,
  output pmode_e mode_q,
  output logic   drive_en_q
);

  logic rst_seen_q;

  always_ff @(posedge clk) begin
    rst_seen_q <= rst;
    if (rst) begin
      mode_q     <= MODE_GEN;
      drive_en_q <= 1'b0;
    end else begin
      mode_q     <= pmode_e'(check_mode_i);
      drive_en_q <= ~check_mode_i;
    end
  end

  // R6: after a reset edge the line is released and the mode is generate
  always_comb begin
    if (rst_seen_q) begin
      assert_reset_release_R6: assert (!drive_en_q && mode_q == MODE_GEN);
    end
  end

  // R5: never drive while checking
  assert_check_released_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_CHECK) |-> !drive_en_q);

  // R2: enable follows the sampled mode one edge later
  assert_enable_follows_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (drive_en_q == !$past(check_mode_i)));

endmodule

// File: rtl/par_bus_unit.sv
module par_bus_unit
  import parbus_pkg::*;
#(
  parameter  int unsigned N_SLICES = 2,
  localparam int unsigned DW       = word_bits(N_SLICES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          check_mode,
  input  logic [DW-1:0] data_in,
  input  logic          par_in,
  output logic          par_out,
  output logic          par_oe,
  output logic          err_n
);

  logic   tree_odd;
  pmode_e mode_now;
  logic   drive_en;

  par_chain #(.N_SLICES(N_SLICES)) u_chain (
    .data_i      (data_in),
    .total_odd_o (tree_odd)
  );

  par_mode_ctl u_ctl (
    .clk          (clk),
    .rst          (rst),
    .check_mode_i (check_mode),
    .mode_q       (mode_now),
    .drive_en_q   (drive_en)
  );

  always_comb begin
    par_out = line_value(tree_odd);
    par_oe  = drive_en;
    err_n   = verdict_n(mode_now, tree_odd, par_in);
  end

  // R1: line value against a flat reduction of the whole word
  assert_line_even_R1: assert property (@(posedge clk) disable iff (rst)
    par_out == ~(^data_in));

  // R3: no error flag while generating
  assert_gen_err_high_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_now == MODE_GEN) |-> err_n);

  // R4: check verdict against data plus line
  assert_check_verdict_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_now == MODE_CHECK) |-> (err_n == (^{data_in, par_in})));

endmodule

// File: tb/tb_par_bus_unit.sv
module tb_par_bus_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NS         = 2;
  localparam int DW         = 8 * NS + 1;
  localparam int NVEC       = 12;

  // {data[16:0], mode, par_in, exp_par, exp_err_n}
  localparam logic [DW+3:0] VEC [NVEC] = '{
    {17'h00000, 1'b0, 1'b0, 1'b1, 1'b1},
    {17'h00001, 1'b0, 1'b0, 1'b0, 1'b1},
    {17'h1FFFF, 1'b0, 1'b1, 1'b0, 1'b1},
    {17'h10000, 1'b0, 1'b0, 1'b0, 1'b1},
    {17'h00100, 1'b0, 1'b1, 1'b0, 1'b1},
    {17'h00003, 1'b1, 1'b0, 1'b1, 1'b0},
    {17'h00003, 1'b1, 1'b1, 1'b1, 1'b1},
    {17'h00007, 1'b1, 1'b1, 1'b0, 1'b0},
    {17'h00007, 1'b1, 1'b0, 1'b0, 1'b1},
    {17'h1FFFF, 1'b1, 1'b1, 1'b0, 1'b0},
    {17'h0F0F0, 1'b1, 1'b1, 1'b1, 1'b1},
    {17'h00000, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          check_mode = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic          par_in = 1'b0;
  logic          par_out, par_oe, err_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  par_bus_unit #(.N_SLICES(NS)) dut (
    .clk        (clk),
    .rst        (rst),
    .check_mode (check_mode),
    .data_in    (data_in),
    .par_in     (par_in),
    .par_out    (par_out),
    .par_oe     (par_oe),
    .err_n      (err_n)
  );

  function automatic int ones_in(logic [DW-1:0] d);
    int c = 0;
    for (int i = 0; i < DW; i++) c += int'(d[i]);
    return c;
  endfunction

  task automatic cmp(string tag, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(logic m, logic [DW-1:0] d, logic p);
    @(negedge clk);
    check_mode = m;
    data_in    = d;
    par_in     = p;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    // reset state, R6
    repeat (2) @(posedge clk);
    @(negedge clk);
    cmp("R6 reset par_oe", par_oe, 1'b0);
    cmp("R6 reset err_n", err_n, 1'b1);
    // reset overrides a check request with a mismatching line
    check_mode = 1'b1; data_in = 17'h00003; par_in = 1'b0;
    @(posedge clk); @(negedge clk);
    cmp("R6 reset err_n under check request", err_n, 1'b1);
    cmp("R6 reset par_oe under check request", par_oe, 1'b0);
    check_mode = 1'b0;
    @(posedge clk); @(negedge clk);
    cmp("R6 reset par_oe under drive request", par_oe, 1'b0);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    cmp("R2 enable after reset release", par_oe, 1'b1);

    // vector table: R1 R3 R4 R5 R7
    for (int v = 0; v < NVEC; v++) begin
      logic [DW+3:0] e;
      e = VEC[v];
      apply(e[3], e[DW+3:4], e[2]);
      cmp($sformatf("R1 table par_out v%0d", v), par_out, e[1]);
      cmp($sformatf("R4/R3 table err_n v%0d", v), err_n, e[0]);
      cmp($sformatf("R2/R5 table par_oe v%0d", v), par_oe, ~e[3]);
    end

    // walking one across both slices, R7
    for (int i = 0; i < DW; i++) begin
      apply(1'b0, DW'(1) << i, 1'b0);
      cmp($sformatf("R7 single one at bit %0d", i), par_out, 1'b0);
    end

    // random words and modes, R1 R3 R4
    for (int r = 0; r < 300; r++) begin
      logic [DW-1:0] d;
      logic m, p, ep, ee;
      d  = DW'($urandom);
      m  = 1'($urandom);
      p  = 1'($urandom);
      ep = (ones_in(d) % 2) == 0;
      ee = m ? (((ones_in(d) + int'(p)) % 2) != 0) : 1'b1;
      apply(m, d, p);
      cmp("R1 random par_out", par_out, ep);
      cmp(m ? "R4 random err_n" : "R3 random err_n", err_n, ee);
      if (m) cmp("R5 random par_oe", par_oe, 1'b0);
    end

    // mid-cycle flip of the line in check mode, R8
    apply(1'b1, 17'h00005, 1'b0);
    cmp("R8 before flip err_n", err_n, 1'b0);
    #2 par_in = 1'b1;
    #1 cmp("R8 after flip err_n", err_n, 1'b1);
    #1 par_in = 1'b0;
    #0.5 cmp("R8 flip back err_n", err_n, 1'b0);

    // mode change: enable lags by one edge, R2
    @(negedge clk);
    check_mode = 1'b0;
    cmp("R2 enable before edge", par_oe, 1'b0);
    @(posedge clk); @(negedge clk);
    cmp("R2 enable after edge", par_oe, 1'b1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule